// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a 32-bit physical address for a requester that holds one translation request at a time. It checks a small, fully associative cache of recent translations first. On a miss, or when a write lands on a cached page that has not yet been marked dirty, it walks a two-level table in memory. It reads a directory entry and then a table entry, applies the access rights of both levels, and writes the accessed and dirty flags back into memory. The result is either a physical address or a fault that carries a cause and a small code.

The directory base is loaded through a write strobe. Any such write empties the translation cache. Memory is reached through a single request/acknowledge port that carries one 32-bit word per access. Each request stays on `req_valid` with its fields held until the cycle in which `req_ready` rises. The response fields are valid in that same cycle.

Top module: `ptw_top`

## Requirements
- R1: The directory entry is read at {base[31:12], lin[31:22], 2'b00} and the table entry at {dir_entry[31:12], lin[21:12], 2'b00}. A successful translation returns {table_entry[31:12], lin[11:0]}. Entry bits 11:9 have no effect on the result and are written back unchanged.
- R2: A directory entry with bit 0 (present) clear ends the walk after one read, with rsp_fault=1 and rsp_cause=2'b01. No memory write occurs.
- R3: A table entry with bit 0 clear ends the walk after two reads, with rsp_cause=2'b10. No memory write occurs.
- R4: A user request (req_user=1) needs bit 2 set in both entries. A user write also needs bit 1 set in both entries. A supervisor request is never refused for rights. A refusal gives rsp_cause=2'b11 and no memory write.
- R5: On every response, rsp_code = {req_user, req_write, protection}, where protection is 1 only when rsp_cause=2'b11. On a fault, rsp_phys is 0 and rsp_fault=1. On success, rsp_cause=2'b00.
- R6: A successful walk sets bit 5 (accessed) in both entries. An entry is written only when a flag in it must change.
- R7: Bit 6 (dirty) is set only in the table entry, and only on a write. The directory entry's bit 6 is never changed.
- R8: A repeated translation that hits the cache returns the same result with no memory access. A user request that hits an entry without the needed rights faults with rsp_cause=2'b11, also with no memory access.
- R9: A write that hits a cached entry filled without the dirty flag performs a full walk, so that the dirty flag is written to memory. After that, writes to the page hit.
- R10: A pulse on base_we empties the cache, so the next translation of any page walks again.
- R11: The cache holds TLB_ENTRIES pages (8 by default) and replaces them in round-robin order. After 9 distinct fills, the first page filled misses and the other 8 hit.
- R12: After reset, req_ready and mem_req are 0. req_ready is high only while req_valid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| base_we | input | 1 | Load directory base and flush the cache |
| base_wdata | input | 32 | New directory base (bits 31:12 used) |
| req_valid | input | 1 | Translation request pending |
| req_ready | output | 1 | Response valid; request consumed |
| req_lin | input | 32 | Linear address |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is at user level |
| rsp_fault | output | 1 | Translation failed |
| rsp_cause | output | 2 | 00 ok, 01 directory absent, 10 table absent, 11 rights |
| rsp_code | output | 3 | {user, write, protection} |
| rsp_phys | output | 32 | Physical address (0 on fault) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Byte address of the entry |
| mem_wdata | output | 32 | Entry write data |
| mem_ack | input | 1 | Access completes this cycle |
| mem_rdata | input | 32 | Entry read data, valid with mem_ack |

## Verification
The hardest state to reach from the ports is a cache hit whose stored flags differ from what the request needs. Examples are a write to a page cached by an earlier read, and a user access to a page cached by a supervisor walk. Here the block must choose between answering at once and walking again. The bench creates these states with sequences of requests: first a read or supervisor request to fill an entry, then the conflicting request. It tells hits from walks by counting memory reads. A sweep over every combination of both levels' present, write and user flags with every request type covers the fault ordering. Filling nine pages shows the round-robin eviction.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
   localparam int PTE_P = 0;
   localparam int PTE_W = 1;
   localparam int PTE_U = 2;
   localparam int PTE_A = 5;
   localparam int PTE_D = 6;

   typedef enum logic [1:0] {
      CAUSE_NONE   = 2'b00,
      CAUSE_NP_DIR = 2'b01,
      CAUSE_NP_TBL = 2'b10,
      CAUSE_PROT   = 2'b11
   } cause_e;

   typedef enum logic [2:0] {
      WK_IDLE, WK_RD_DIR, WK_RD_TBL, WK_WR_DIR, WK_WR_TBL, WK_RESP
   } walk_state_e;
endpackage

// File: rtl/ptw_tlb.sv
module ptw_tlb #(
   parameter int ENTRIES = 8,
   parameter int TAG_W   = 20,
   parameter int FRAME_W = 20
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               flush,
   input  logic               fill,
   input  logic [TAG_W-1:0]   tag,
   input  logic [FRAME_W-1:0] fill_frame,
   input  logic               fill_uok,
   input  logic               fill_wok,
   input  logic               fill_dirty,
   output logic               hit,
   output logic [FRAME_W-1:0] hit_frame,
   output logic               hit_uok,
   output logic               hit_wok,
   output logic               hit_dirty
);
   localparam int IDX_W = $clog2(ENTRIES);

   if (ENTRIES < 2 || (ENTRIES & (ENTRIES - 1)) != 0) begin : g_bad_entries
      $error("ptw_tlb: ENTRIES must be a power of two of at least 2");
   end

   logic [ENTRIES-1:0] match;
   logic [IDX_W-1:0]   rr_q;
   logic               vld_q   [ENTRIES];
   logic [TAG_W-1:0]   tag_q   [ENTRIES];
   logic [FRAME_W-1:0] frame_q [ENTRIES];
   logic               uok_q   [ENTRIES];
   logic               wok_q   [ENTRIES];
   logic               dirty_q [ENTRIES];

   assign hit = |match;

   for (genvar i = 0; i < ENTRIES; i++) begin : g_entry
      logic sel;
      assign match[i] = vld_q[i] && (tag_q[i] == tag);
      assign sel = fill && (hit ? match[i] : (rr_q == IDX_W'(i)));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vld_q[i]   <= 1'b0;
            tag_q[i]   <= '0;
            frame_q[i] <= '0;
            uok_q[i]   <= 1'b0;
            wok_q[i]   <= 1'b0;
            dirty_q[i] <= 1'b0;
         end else if (flush) begin
            vld_q[i]   <= 1'b0;
         end else if (sel) begin
            vld_q[i]   <= 1'b1;
            tag_q[i]   <= tag;
            frame_q[i] <= fill_frame;
            uok_q[i]   <= fill_uok;
            wok_q[i]   <= fill_wok;
            dirty_q[i] <= fill_dirty;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       rr_q <= '0;
      else if (flush)                   rr_q <= '0;
      else if (fill && !hit)            rr_q <= rr_q + 1'b1;
   end

   always_comb begin
      hit_frame = '0;
      hit_uok   = 1'b0;
      hit_wok   = 1'b0;
      hit_dirty = 1'b0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (match[i]) begin
            hit_frame = hit_frame | frame_q[i];
            hit_uok   = hit_uok | uok_q[i];
            hit_wok   = hit_wok | wok_q[i];
            hit_dirty = hit_dirty | dirty_q[i];
         end
      end
   end

   AST_TAG_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(match)); // R8
   AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !hit); // R10
endmodule

// File: rtl/ptw_walk.sv
module ptw_walk
   import ptw_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start,
   input  logic [19:0] vpn,
   input  logic        wr,
   input  logic        us,
   input  logic [19:0] base_frame,
   output logic        mem_req,
   output logic        mem_we,
   output logic [31:0] mem_addr,
   output logic [31:0] mem_wdata,
   input  logic        mem_ack,
   input  logic [31:0] mem_rdata,
   output logic        idle,
   output logic        done,
   output cause_e      cause,
   output logic [19:0] frame,
   output logic        uok,
   output logic        wok,
   output logic        dirty
);
   walk_state_e st_q;
   cause_e      cause_q;
   logic [31:0] dir_q, tbl_q;
   logic [31:0] dir_addr, tbl_addr, tbl_set;
   logic        rd_uok, rd_wok, rd_prot;

   assign dir_addr = {base_frame, vpn[19:10], 2'b00};
   assign tbl_addr = {dir_q[31:12], vpn[9:0], 2'b00};

   // rights seen when the table entry arrives
   assign rd_uok  = dir_q[PTE_U] && mem_rdata[PTE_U];
   assign rd_wok  = dir_q[PTE_W] && mem_rdata[PTE_W];
   assign rd_prot = us && (!rd_uok || (wr && !rd_wok));

   function automatic logic tbl_needs_wb(input logic [31:0] e, input logic w);
      return !e[PTE_A] || (w && !e[PTE_D]);
   endfunction

   always_comb begin
      tbl_set = tbl_q;
      tbl_set[PTE_A] = 1'b1;
      if (wr) tbl_set[PTE_D] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= WK_IDLE;
         cause_q <= CAUSE_NONE;
         dir_q   <= '0;
         tbl_q   <= '0;
      end else begin
         unique case (st_q)
            WK_IDLE: if (start) begin
               st_q    <= WK_RD_DIR;
               cause_q <= CAUSE_NONE;
            end
            WK_RD_DIR: if (mem_ack) begin
               dir_q <= mem_rdata;
               if (!mem_rdata[PTE_P]) begin
                  cause_q <= CAUSE_NP_DIR;
                  st_q    <= WK_RESP;
               end else begin
                  st_q    <= WK_RD_TBL;
               end
            end
            WK_RD_TBL: if (mem_ack) begin
               tbl_q <= mem_rdata;
               if (!mem_rdata[PTE_P]) begin
                  cause_q <= CAUSE_NP_TBL;
                  st_q    <= WK_RESP;
               end else if (rd_prot) begin
                  cause_q <= CAUSE_PROT;
                  st_q    <= WK_RESP;
               end else if (!dir_q[PTE_A])              st_q <= WK_WR_DIR;
               else if (tbl_needs_wb(mem_rdata, wr))    st_q <= WK_WR_TBL;
               else                                     st_q <= WK_RESP;
            end
            WK_WR_DIR: if (mem_ack) begin
               dir_q[PTE_A] <= 1'b1;
               st_q <= tbl_needs_wb(tbl_q, wr) ? WK_WR_TBL : WK_RESP;
            end
            WK_WR_TBL: if (mem_ack) begin
               tbl_q <= tbl_set;
               st_q  <= WK_RESP;
            end
            default: st_q <= WK_IDLE;
         endcase
      end
   end

   always_comb begin
      mem_req   = (st_q == WK_RD_DIR) || (st_q == WK_RD_TBL) ||
                  (st_q == WK_WR_DIR) || (st_q == WK_WR_TBL);
      mem_we    = (st_q == WK_WR_DIR) || (st_q == WK_WR_TBL);
      mem_addr  = ((st_q == WK_RD_DIR) || (st_q == WK_WR_DIR)) ? dir_addr : tbl_addr;
      mem_wdata = tbl_set;
      if (st_q == WK_WR_DIR) begin
         mem_wdata = dir_q;
         mem_wdata[PTE_A] = 1'b1;
      end
   end

   assign idle  = (st_q == WK_IDLE);
   assign done  = (st_q == WK_RESP);
   assign cause = cause_q;
   assign frame = tbl_q[31:12];
   assign uok   = dir_q[PTE_U] && tbl_q[PTE_U];
   assign wok   = dir_q[PTE_W] && tbl_q[PTE_W];
   assign dirty = tbl_q[PTE_D] || wr;

   AST_WB_SETS_ACCESSED: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> mem_wdata[PTE_A]); // R6
   AST_WB_NEVER_ON_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> (cause_q == CAUSE_NONE)); // R6
   AST_DIR_DIRTY_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == WK_WR_DIR) |-> (mem_wdata[PTE_D] == dir_q[PTE_D])); // R7
   AST_DIRTY_ONLY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      ((st_q == WK_WR_TBL) && mem_wdata[PTE_D]) |-> (wr || tbl_q[PTE_D])); // R7
endmodule

// File: rtl/ptw_top.sv
module ptw_top
   import ptw_pkg::*;
#(
   parameter int TLB_ENTRIES = 8
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        base_we,
   input  logic [31:0] base_wdata,
   input  logic        req_valid,
   output logic        req_ready,
   input  logic [31:0] req_lin,
   input  logic        req_write,
   input  logic        req_user,
   output logic        rsp_fault,
   output logic [1:0]  rsp_cause,
   output logic [2:0]  rsp_code,
   output logic [31:0] rsp_phys,
   output logic        mem_req,
   output logic        mem_we,
   output logic [31:0] mem_addr,
   output logic [31:0] mem_wdata,
   input  logic        mem_ack,
   input  logic [31:0] mem_rdata
);
   localparam int OFF_W = 12;
   localparam int VPN_W = 32 - OFF_W;

   logic [VPN_W-1:0] base_q, hit_frame, wk_frame, frame_sel;
   logic             stale_q;
   logic             hit, hit_uok, hit_wok, hit_dirty, use_hit, hit_prot;
   logic             wk_idle, wk_done, wk_uok, wk_wok, wk_dirty, start, fill;
   cause_e           wk_cause, cause_sel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        base_q <= '0;
      else if (base_we)  base_q <= base_wdata[31:OFF_W];
   end

   // a base reload during a walk keeps the stale result out of the cache
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   stale_q <= 1'b0;
      else if (base_we && !wk_idle) stale_q <= 1'b1;
      else if (wk_done)             stale_q <= 1'b0;
   end

   assign use_hit  = hit && !(req_write && !hit_dirty);
   assign hit_prot = req_user && (!hit_uok || (req_write && !hit_wok));
   assign start    = req_valid && !use_hit;
   assign fill     = wk_done && (wk_cause == CAUSE_NONE) && !stale_q;

   ptw_tlb #(.ENTRIES(TLB_ENTRIES), .TAG_W(VPN_W), .FRAME_W(VPN_W)) u_tlb (
      .clk(clk), .rst_n(rst_n), .flush(base_we), .fill(fill),
      .tag(req_lin[31:OFF_W]), .fill_frame(wk_frame), .fill_uok(wk_uok),
      .fill_wok(wk_wok), .fill_dirty(wk_dirty), .hit(hit),
      .hit_frame(hit_frame), .hit_uok(hit_uok), .hit_wok(hit_wok),
      .hit_dirty(hit_dirty)
   );

   ptw_walk u_walk (
      .clk(clk), .rst_n(rst_n), .start(start), .vpn(req_lin[31:OFF_W]),
      .wr(req_write), .us(req_user), .base_frame(base_q),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
      .idle(wk_idle), .done(wk_done), .cause(wk_cause), .frame(wk_frame),
      .uok(wk_uok), .wok(wk_wok), .dirty(wk_dirty)
   );

   always_comb begin
      if (wk_done) begin
         cause_sel = wk_cause;
         frame_sel = wk_frame;
      end else begin
         cause_sel = hit_prot ? CAUSE_PROT : CAUSE_NONE;
         frame_sel = hit_frame;
      end
   end

   assign req_ready = wk_done || (req_valid && use_hit && wk_idle);
   assign rsp_cause = cause_sel;
   assign rsp_fault = (cause_sel != CAUSE_NONE);
   assign rsp_code  = {req_user, req_write, cause_sel == CAUSE_PROT};
   assign rsp_phys  = rsp_fault ? '0 : {frame_sel, req_lin[OFF_W-1:0]};

   AST_READY_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> req_valid); // R12
   AST_HIT_NO_MEMORY: assert property (@(posedge clk) disable iff (!rst_n)
      (req_ready && !wk_done) |-> !mem_req); // R8
endmodule

// File: tb/ptw_top_bench.sv
module ptw_top_bench;
   localparam int CLK_PERIOD = 10;
   localparam logic [31:0] BASE = 32'h0000_1000;
   localparam logic [9:0]  DIDX = 10'd5;

   logic clk = 1'b0, rst_n = 1'b0;
   logic base_we = 1'b0;
   logic [31:0] base_wdata = '0;
   logic req_valid = 1'b0, req_write = 1'b0, req_user = 1'b0;
   logic [31:0] req_lin = '0;
   logic req_ready, rsp_fault, mem_req, mem_we, mem_ack;
   logic [1:0] rsp_cause;
   logic [2:0] rsp_code;
   logic [31:0] rsp_phys, mem_addr, mem_wdata, mem_rdata;

   logic [31:0] mem [4096];
   int nrd, nwr, tests, fails;
   logic r_fault;
   logic [1:0] r_cause;
   logic [2:0] r_code;
   logic [31:0] r_phys;

   always #(CLK_PERIOD/2) clk = ~clk;

   ptw_top u_ptw_top (
      .clk(clk), .rst_n(rst_n), .base_we(base_we), .base_wdata(base_wdata),
      .req_valid(req_valid), .req_ready(req_ready), .req_lin(req_lin),
      .req_write(req_write), .req_user(req_user), .rsp_fault(rsp_fault),
      .rsp_cause(rsp_cause), .rsp_code(rsp_code), .rsp_phys(rsp_phys),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
   );

   assign mem_ack   = mem_req;
   assign mem_rdata = mem[mem_addr[13:2]];

   always @(posedge clk) begin
      if (mem_req && mem_we) begin
         mem[mem_addr[13:2]] <= mem_wdata;
         nwr <= nwr + 1;
      end else if (mem_req) begin
         nrd <= nrd + 1;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] tbl_word_addr(input logic [9:0] t);
      return 32'h0000_2000 + {20'd0, t, 2'b00};
   endfunction

   task automatic load_base();
      @(negedge clk);
      base_we = 1'b1; base_wdata = BASE;
      @(negedge clk);
      base_we = 1'b0;
   endtask

   task automatic do_req(input logic [31:0] lin, input logic wr, input logic us);
      @(negedge clk);
      nrd = 0; nwr = 0;
      req_valid = 1'b1; req_lin = lin; req_write = wr; req_user = us;
      #1;
      while (!req_ready) begin @(negedge clk); #1; end
      r_fault = rsp_fault; r_cause = rsp_cause; r_code = rsp_code; r_phys = rsp_phys;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   function automatic logic [31:0] lin_of(input logic [9:0] t, input logic [11:0] off);
      return {DIDX, t, off};
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      tests = 0; fails = 0; nrd = 0; nwr = 0;
      for (int i = 0; i < 4096; i++) mem[i] = '0;
      repeat (3) @(negedge clk);
      #1;
      chk("R12 reset req_ready", {31'd0, req_ready}, 0);
      chk("R12 reset mem_req", {31'd0, mem_req}, 0);
      rst_n = 1'b1;
      @(negedge clk); #1;
      chk("R12 idle ready low", {31'd0, req_ready}, 0);

      // Sweep every flag combination of both levels and request kind
      for (int c = 0; c < 256; c++) begin
         logic [2:0] df, tf;
         logic wr, us;
         logic [31:0] dent, tent, lin, ephys;
         logic [1:0] ec;
         logic [9:0] tix;
         logic [11:0] off;
         df = c[2:0]; tf = c[5:3]; wr = c[6]; us = c[7];
         tix = 10'(c & 15);
         off = 12'((c * 37) & 32'hfff);
         dent = 32'h0000_2A00 | {29'd0, df};
         tent = {20'h30000 + 20'(c), 12'hA00} | {29'd0, tf};
         @(negedge clk);
         mem[(BASE >> 2) + 32'(DIDX)] = dent;
         mem[tbl_word_addr(tix) >> 2] = tent;
         load_base();
         lin = lin_of(tix, off);
         if (!df[0])                                ec = 2'b01;
         else if (!tf[0])                           ec = 2'b10;
         else if (us && !(df[2] && tf[2]))          ec = 2'b11;
         else if (us && wr && !(df[1] && tf[1]))    ec = 2'b11;
         else                                       ec = 2'b00;
         ephys = (ec == 2'b00) ? {tent[31:12], off} : 32'd0;
         do_req(lin, wr, us);
         chk("R2 R3 R4 cause", {30'd0, r_cause}, {30'd0, ec});
         chk("R5 fault flag", {31'd0, r_fault}, {31'd0, ec != 2'b00});
         chk("R5 code", {29'd0, r_code}, {29'd0, us, wr, ec == 2'b11});
         chk("R1 phys", r_phys, ephys);
         chk("R1 R2 reads", 32'(nrd), df[0] ? 32'd2 : 32'd1);
         chk("R6 writes", 32'(nwr), (ec == 2'b00) ? 32'd2 : 32'd0);
         chk("R7 dir entry after", mem[(BASE >> 2) + 32'(DIDX)],
             (ec == 2'b00) ? (dent | 32'h20) : dent);
         chk("R7 tbl entry after", mem[tbl_word_addr(tix) >> 2],
             (ec == 2'b00) ? (tent | 32'h20 | (wr ? 32'h40 : 32'h0)) : tent);
      end

      // Cache behaviour: all rights present in directory, tables 0..9
      @(negedge clk);
      mem[(BASE >> 2) + 32'(DIDX)] = 32'h0000_2007;
      for (int t = 0; t < 10; t++)
         mem[tbl_word_addr(10'(t)) >> 2] = {20'h40000 + 20'(t), 12'h007};
      mem[tbl_word_addr(10'd1) >> 2] = {20'h40001, 12'h003};
      mem[tbl_word_addr(10'd9) >> 2] = {20'h40009, 12'h067};
      load_base();

      do_req(lin_of(10'd0, 12'h123), 1'b0, 1'b1);
      chk("R8 first read walks", 32'(nrd), 2);
      do_req(lin_of(10'd0, 12'h456), 1'b0, 1'b1);
      chk("R8 repeat read hits", 32'(nrd + nwr), 0);
      chk("R8 hit phys", r_phys, 32'h4000_0456);

      do_req(lin_of(10'd0, 12'h010), 1'b1, 1'b1);
      chk("R9 write after read walks", 32'(nrd), 2);
      chk("R9 dirty written", mem[tbl_word_addr(10'd0) >> 2], 32'h4000_0067);
      do_req(lin_of(10'd0, 12'h014), 1'b1, 1'b1);
      chk("R9 second write hits", 32'(nrd + nwr), 0);
      chk("R9 hit phys", r_phys, 32'h4000_0014);

      do_req(lin_of(10'd1, 12'h000), 1'b0, 1'b0);
      chk("R4 supervisor on supervisor page", {31'd0, r_fault}, 0);
      do_req(lin_of(10'd1, 12'h000), 1'b0, 1'b1);
      chk("R8 user hit refused", {30'd0, r_cause}, 3);
      chk("R8 user hit code", {29'd0, r_code}, 3'b101);
      chk("R8 refused hit no memory", 32'(nrd + nwr), 0);

      do_req(lin_of(10'd9, 12'h000), 1'b1, 1'b0);
      chk("R6 flags already set reads", 32'(nrd), 2);
      chk("R6 flags already set no write", 32'(nwr), 0);

      // Round robin: 9 distinct fills after a flush
      load_base();
      for (int t = 0; t < 9; t++) do_req(lin_of(10'(t), 12'h0), 1'b0, 1'b0);
      for (int t = 1; t < 9; t++) begin
         do_req(lin_of(10'(t), 12'h0), 1'b0, 1'b0);
         chk("R11 kept page hits", 32'(nrd), 0);
      end
      do_req(lin_of(10'd0, 12'h0), 1'b0, 1'b0);
      chk("R11 oldest page evicted", 32'(nrd), 2);

      do_req(lin_of(10'd5, 12'h0), 1'b0, 1'b0);
      chk("R10 cached before reload", 32'(nrd), 0);
      load_base();
      do_req(lin_of(10'd5, 12'h0), 1'b0, 1'b0);
      chk("R10 walk after reload", 32'(nrd), 2);
      #1;
      chk("R12 ready low after response", {31'd0, req_ready}, 0);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule